// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets a system host reach a small bank of 8-bit configuration registers over a two-wire serial management bus. It runs on a fast system clock and treats the bus clock and data lines as ordinary inputs. Both lines are synchronized and filtered, and their edges are found inside the block. The data line is driven only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The slave answers on a seven-bit address made of a fixed base plus four strap bits. It handles a single-register write, and a single-register read that uses a repeated START.

The register contents go to a live control bus, but only through a gate. While the gate bit is clear, the host can write and read back registers and nothing changes downstream. Once the gate bit is set, the live bus follows the registers. The registers return to their defaults on reset, when the mode input drops, or through a self-clearing reset bit. Register 0 is a read-only status word that reports the strap bits, an external load-done flag and the power-down input.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset, every register holds its default: index 0x06 = 0x10, 0x07 = 0x01, 0x0B = 0x70, 0x0F = 0x2F, all others 0x00. `sda_oe` is low. Byte i of `ctl_live` (bits 8i+7..8i) equals the default of index i.
- R2: The slave address is 0x58 + `strap_addr`. An address byte whose top seven bits match is acknowledged: the slave pulls SDA low in the ninth clock. Any other address gets no acknowledge.
- R3: A write (START, address with R/W=0, index, data, STOP) stores the data byte at that index when 1 <= index <= 0x0F.
- R4: A read (START, address with R/W=0, index, repeated START, address with R/W=1, one byte out MSB first, host NACK, STOP) returns the current contents of the index.
- R5: Index 0x00 reads {`pwr_dn`, `strap_addr`[3:0], `load_done`, 2'b00}, from bit 7 down to bit 0. Writes to it are ignored.
- R6: Indices 0x10 and above are acknowledged. They read as 0x00, and writes to them are dropped.
- R7: Writing a byte with bit 6 set to index 0x07 returns every register to its default on the next cycle. Bit 6 of index 0x07 always reads 0.
- R8: While bit 3 of index 0x06 is 0, `ctl_live` holds its value. While that bit is 1, `ctl_live` follows the registers one cycle later.
- R9: Asserting `pwr_dn` while `mode_en` is high leaves every register unchanged.
- R10: While `mode_en` is low, the registers and `ctl_live` are held at their defaults and the slave does not acknowledge any address.
- R11: Pulses on SCL or SDA shorter than `FILT` clock cycles are ignored. `sda_oe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe | output | 1 | High pulls the data line low |
| strap_addr | input | 4 | Address strap, added to base 0x58 |
| mode_en | input | 1 | Low holds the registers at their defaults and silences the slave |
| pwr_dn | input | 1 | Power-down input, reported in the status word |
| load_done | input | 1 | External load-complete flag, reported in the status word |
| ctl_live | output | NREG*8 | Gated register image, byte i is index i |

## Verification
Writes and reads use several data patterns: 0xA5, 0x5A, 0xFF and 0x66. Inverted or swapped bit positions therefore show up as wrong read-back. Address probes cover the matching address, an off-by-one address and an unrelated one, and they are repeated after the strap changes. This separates a comparison against the strap-derived address from a comparison against a fixed one. One write carries short pulses on both lines. A correct read-back of that write shows that the filter rejected them rather than seeing false edges, START or STOP. The live bus is sampled before and after the gate bit is set, and again after the mode input drops. This separates register storage from what reaches the live controls.

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter int NREG = 16,
  parameter logic [6:0] BASE_ADDR = 7'h58,
  parameter int FILT = 4,
  parameter int GATE_IDX = 6,
  parameter int GATE_BIT = 3,
  parameter int RST_IDX = 7,
  parameter int RST_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        strap_addr,
  input  logic              mode_en,
  input  logic              pwr_dn,
  input  logic              load_done,
  output logic [NREG*8-1:0] ctl_live
);

  localparam int AW = $clog2(NREG);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [7:0] RST_I8  = 8'(RST_IDX);
  localparam logic [7:0] RST_MSK = 8'(1 << RST_BIT);
  localparam logic [AW-1:0] GATE_A = AW'(GATE_IDX);
  localparam logic [AW-1:0] RST_A  = AW'(RST_IDX);

  function automatic logic [7:0] dflt(input int i);
    case (i)
      6:  return 8'h10;
      7:  return 8'h01;
      11: return 8'h70;
      15: return 8'h2F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [NREG*8-1:0] dflt_all();
    logic [NREG*8-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*8 +: 8] = dflt(i);
    return r;
  endfunction

  // line conditioning: two-flop sync, then a stability filter
  logic [1:0] raw, s1, s2, filt, filt_q;
  logic [FW-1:0] cnt [2];
  assign raw = {scl_i, sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; filt <= 2'b11; filt_q <= 2'b11;
      for (int k = 0; k < 2; k++) cnt[k] <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      filt_q <= filt;
      for (int k = 0; k < 2; k++) begin
        if (s2[k] == filt[k]) cnt[k] <= '0;
        else if (cnt[k] == FW'(FILT - 1)) begin
          filt[k] <= s2[k];
          cnt[k]  <= '0;
        end else cnt[k] <= cnt[k] + 1'b1;
      end
    end
  end

  logic scl_f, sda_f, scl_p, sda_p;
  assign {scl_f, sda_f} = filt;
  assign {scl_p, sda_p} = filt_q;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  logic [6:0] my_addr;
  assign my_addr = BASE_ADDR + {3'b000, strap_addr};

  // register storage
  logic [7:0] regs [NREG];
  logic       soft_rst;
  logic       wr_en;
  logic [7:0] wr_data, idx, rd_byte;

  assign rd_byte = (idx == 8'h00) ? {pwr_dn, strap_addr, load_done, 2'b00} :
                   (int'(idx) < NREG) ? regs[idx[AW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
      soft_rst <= 1'b0;
    end else if (!mode_en || soft_rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
      soft_rst <= 1'b0;
    end else if (wr_en && idx != 8'h00 && int'(idx) < NREG) begin
      if (idx == RST_I8) begin
        regs[RST_A] <= wr_data & ~RST_MSK;
        soft_rst    <= |(wr_data & RST_MSK);
      end else regs[idx[AW-1:0]] <= wr_data;
    end
  end

  // gated live image
  logic [NREG*8-1:0] reg_flat;
  always_comb for (int i = 0; i < NREG; i++) reg_flat[i*8 +: 8] = regs[i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_live <= dflt_all();
    else if (!mode_en) ctl_live <= dflt_all();
    else if (regs[GATE_A][GATE_BIT]) ctl_live <= reg_flat;
  end

  // bus protocol
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_DATA} ph_t;
  st_t st;
  ph_t ph;
  logic [3:0] bcnt;
  logic [7:0] sr;
  logic       rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_ADDR; bcnt <= '0; sr <= '0; rw <= 1'b0;
      idx <= '0; sda_oe <= 1'b0; wr_en <= 1'b0; wr_data <= '0;
    end else if (!mode_en) begin
      st <= S_IDLE; ph <= PH_ADDR; bcnt <= '0; sda_oe <= 1'b0; wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st <= S_RX; ph <= PH_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sr   <= {sr[6:0], sda_f};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == 4'd8) begin
              case (ph)
                PH_ADDR: begin
                  if (sr[7:1] == my_addr) begin
                    rw <= sr[0]; sda_oe <= 1'b1; st <= S_ACK;
                  end else st <= S_IDLE;
                end
                PH_IDX: begin
                  idx <= sr; sda_oe <= 1'b1; st <= S_ACK;
                end
                default: begin
                  wr_en <= 1'b1; wr_data <= sr; sda_oe <= 1'b1; st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              case (ph)
                PH_ADDR: begin
                  if (rw) begin
                    st <= S_TX; sr <= rd_byte; sda_oe <= ~rd_byte[7]; bcnt <= 4'd1;
                  end else begin
                    st <= S_RX; ph <= PH_IDX;
                  end
                end
                PH_IDX: begin
                  st <= S_RX; ph <= PH_DATA;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                sda_oe <= ~sr[~bcnt[2:0]];
                bcnt   <= bcnt + 1'b1;
              end
            end
          end
          S_MACK: if (scl_rise) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (regs[RST_A] == dflt(RST_IDX) && regs[GATE_A] == dflt(GATE_IDX)));

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && !regs[GATE_A][GATE_BIT]) |=> (!mode_en || $stable(ctl_live)));

  p_mode_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !sda_oe);

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && $past(mode_en) && scl_f && $past(scl_f)) |-> $stable(sda_oe));

  p_mode_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!mode_en || ctl_live == dflt_all()));

endmodule

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb;
  localparam int CLK_NS = 10;
  localparam int Q = 10;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_low = 1'b0, g_sda = 1'b0, g_scl = 1'b0, glitch_arm = 1'b0;
  logic [3:0] strap = 4'h0;
  logic mode_en = 1'b1, pwr_dn = 1'b0, load_done = 1'b0;
  logic sda_oe;
  logic [127:0] ctl_live;
  logic sda_bus, scl_bus;

  assign sda_bus = !(host_low || sda_oe || g_sda);
  assign scl_bus = host_scl && !g_scl;

  always #(CLK_NS/2) clk = ~clk;

  cfg_smbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_addr(strap), .mode_en(mode_en), .pwr_dn(pwr_dn), .load_done(load_done),
    .ctl_live(ctl_live)
  );

  string exp_r[$];
  logic [7:0] exp_v[$];
  logic [7:0] obs_v[$];
  int chk_n = 0, fail_n = 0;
  bit fin = 0;

  task automatic expect_item(input string rq, input logic [7:0] v);
    exp_r.push_back(rq); exp_v.push_back(v);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_v.push_back(v);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (obs_v.size() > 0) begin
        automatic logic [7:0] o = obs_v.pop_front();
        chk_n++;
        if (exp_v.size() == 0) begin
          fail_n++;
          $display("FAIL unexpected result actual=%02h expected=none", o);
        end else begin
          automatic string r = exp_r.pop_front();
          automatic logic [7:0] e = exp_v.pop_front();
          if (o !== e) begin
            fail_n++;
            $display("FAIL %s actual=%02h expected=%02h", r, o, e);
          end
        end
      end
    end
  end

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic h_start();
    host_low = 1'b0; q(); host_scl = 1'b1; q(); host_low = 1'b1; q(); host_scl = 1'b0; q();
  endtask

  task automatic h_stop();
    host_low = 1'b1; q(); host_scl = 1'b1; q(); host_low = 1'b0; q();
  endtask

  task automatic h_wbit(input logic b);
    host_low = !b;
    if (glitch_arm) begin
      repeat (2) @(negedge clk); g_scl = 1'b1; repeat (2) @(negedge clk); g_scl = 1'b0;
      repeat (Q-4) @(negedge clk);
    end else q();
    host_scl = 1'b1; q();
    if (glitch_arm && b) begin
      g_sda = 1'b1; repeat (2) @(negedge clk); g_sda = 1'b0; repeat (Q-2) @(negedge clk);
    end else q();
    host_scl = 1'b0; q();
  endtask

  task automatic h_rbit(output logic b);
    host_low = 1'b0; q(); host_scl = 1'b1; q(); b = sda_bus; q(); host_scl = 1'b0; q();
  endtask

  task automatic h_wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) h_wbit(d[i]);
    h_rbit(ack);
  endtask

  task automatic h_rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) h_rbit(d[i]);
    h_wbit(1'b1);
  endtask

  task automatic ack_probe(input string rq, input logic [6:0] a, input logic exp_nack);
    logic ack;
    expect_item(rq, {7'b0, exp_nack});
    h_start(); h_wbyte({a, 1'b0}, ack); observe({7'b0, ack}); h_stop();
  endtask

  task automatic wr_reg(input string rq, input logic [6:0] a, input logic [7:0] ix, input logic [7:0] d);
    logic ack;
    expect_item(rq, 8'h00);
    h_start(); h_wbyte({a, 1'b0}, ack); observe({7'b0, ack});
    if (!ack) begin
      h_wbyte(ix, ack); h_wbyte(d, ack);
    end
    h_stop();
  endtask

  task automatic rd_reg(input string rq, input logic [6:0] a, input logic [7:0] ix, input logic [7:0] e);
    logic ack;
    logic [7:0] d;
    expect_item(rq, e);
    h_start(); h_wbyte({a, 1'b0}, ack); h_wbyte(ix, ack);
    h_start(); h_wbyte({a, 1'b1}, ack); h_rbyte(d); h_stop();
    observe(d);
  endtask

  task automatic chk_live(input string rq, input int i, input logic [7:0] e);
    expect_item(rq, e);
    repeat (3) @(negedge clk);
    observe(ctl_live[i*8 +: 8]);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk_n, fail_n);
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!fin) begin
      fail_n++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    expect_item("R1 sda_oe idle", 8'h00); observe({7'b0, sda_oe});
    chk_live("R1 live[6] default", 6, 8'h10);
    chk_live("R1 live[7] default", 7, 8'h01);
    chk_live("R1 live[11] default", 11, 8'h70);
    chk_live("R1 live[15] default", 15, 8'h2F);
    rd_reg("R1 read default 0x0B", 7'h58, 8'h0B, 8'h70);

    ack_probe("R2 match 0x58 acked", 7'h58, 1'b0);
    ack_probe("R2 0x59 not acked", 7'h59, 1'b1);
    ack_probe("R2 0x2C not acked", 7'h2C, 1'b1);

    wr_reg("R3 write idx3 ack", 7'h58, 8'h03, 8'hA5);
    rd_reg("R4 read idx3", 7'h58, 8'h03, 8'hA5);
    wr_reg("R3 write idx9 ack", 7'h58, 8'h09, 8'h5A);
    rd_reg("R4 read idx9", 7'h58, 8'h09, 8'h5A);
    wr_reg("R3 write idx15 ack", 7'h58, 8'h0F, 8'hFF);
    rd_reg("R4 read idx15", 7'h58, 8'h0F, 8'hFF);
    chk_live("R8 live[3] held, gate off", 3, 8'h00);

    rd_reg("R5 status strap0 done0", 7'h58, 8'h00, 8'h00);
    load_done = 1'b1;
    rd_reg("R5 status done1", 7'h58, 8'h00, 8'h04);
    wr_reg("R5 write status ack", 7'h58, 8'h00, 8'hFF);
    rd_reg("R5 status unchanged by write", 7'h58, 8'h00, 8'h04);

    rd_reg("R6 unimplemented reads 0", 7'h58, 8'h40, 8'h00);
    wr_reg("R6 unimplemented write acked", 7'h58, 8'h40, 8'h77);
    rd_reg("R6 unimplemented still 0", 7'h58, 8'h40, 8'h00);

    wr_reg("R8 set gate ack", 7'h58, 8'h06, 8'h18);
    chk_live("R8 live[3] after gate", 3, 8'hA5);
    chk_live("R8 live[6] after gate", 6, 8'h18);
    wr_reg("R8 write idx5 ack", 7'h58, 8'h05, 8'h3C);
    chk_live("R8 live[5] immediate", 5, 8'h3C);

    pwr_dn = 1'b1;
    repeat (20) @(negedge clk);
    rd_reg("R9 idx3 kept under pwr_dn", 7'h58, 8'h03, 8'hA5);
    rd_reg("R9 idx5 kept under pwr_dn", 7'h58, 8'h05, 8'h3C);
    rd_reg("R5 status shows pwr_dn", 7'h58, 8'h00, 8'h84);
    pwr_dn = 1'b0;

    glitch_arm = 1'b1;
    wr_reg("R11 glitched write ack", 7'h58, 8'h0A, 8'h66);
    glitch_arm = 1'b0;
    rd_reg("R11 glitched write stored", 7'h58, 8'h0A, 8'h66);

    wr_reg("R7 soft reset ack", 7'h58, 8'h07, 8'h41);
    rd_reg("R7 idx3 back to default", 7'h58, 8'h03, 8'h00);
    rd_reg("R7 idx7 default, bit6 clear", 7'h58, 8'h07, 8'h01);
    rd_reg("R7 idx6 default", 7'h58, 8'h06, 8'h10);

    strap = 4'hF;
    ack_probe("R2 strap F addr 0x67 acked", 7'h67, 1'b0);
    ack_probe("R2 strap F old 0x58 not acked", 7'h58, 1'b1);
    wr_reg("R3 write via 0x67 ack", 7'h67, 8'h04, 8'hC3);
    rd_reg("R4 read via 0x67", 7'h67, 8'h04, 8'hC3);
    rd_reg("R5 status strap F", 7'h67, 8'h00, 8'h7C);

    mode_en = 1'b0;
    repeat (5) @(negedge clk);
    chk_live("R10 live[6] default in mode off", 6, 8'h10);
    chk_live("R10 live[3] default in mode off", 3, 8'h00);
    ack_probe("R10 no ack in mode off", 7'h67, 1'b1);
    mode_en = 1'b1;
    repeat (5) @(negedge clk);
    rd_reg("R10 idx4 default after mode off", 7'h67, 8'h04, 8'h00);

    repeat (20) @(negedge clk);
    if (exp_v.size() != 0) begin
      fail_n += exp_v.size();
      $display("FAIL %0d results missing actual=none expected=%0d", exp_v.size(), exp_v.size());
    end
    fin = 1;
    summary();
    $finish;
  end
endmodule